// File: doc/BRIEF.md
# Dual-Mode Character Memory Write Controller

This block sits between a host bus and an eight-entry memory that holds 6-bit character codes. Display scan logic reads the codes back. The host writes one code per strobe. The strobe is formed from an active-low chip select and an active-low write line. A mode input decides where each code lands:

- **Random mode (mode low).** The host gives a 3-bit location with each write, on three shared pins.
- **Sequential mode (mode high).** An internal entry counter chooses the location. The counter advances after every accepted write, so successive codes fill the memory from location 0 upward.

In sequential mode the same three shared pins change meaning. Bit 0 becomes an entry enable. Bit 1 becomes an active-low clear. Bit 2 is the position of the "full" indication. Because a pin cannot change direction here, full is driven on a separate output, and bit 2 is ignored as an input in that mode.

When the counter has accepted eight entries, the full output rises and further writes are dropped. This lets several controllers be chained: each one's full output enables the next controller's entry.

All host-side control inputs are asynchronous to the system clock. The block synchronizes them into the clock domain and works on the edges of the combined strobe:

- **Falling edge of the strobe.** The mode, the location and the entry enable are taken at this edge.
- **Rising edge of the strobe.** The character code is taken at this edge, and the write is committed.

A write-active output tells the scan logic that a write is in progress. A shutdown input masks the full output without changing any stored state.

Top module: `charmem_writer`

## Requirements
- R1: After synchronous reset, all eight entries read as the blank code 6'b100000, full_out is 0 and wr_active is 0.
- R2: The strobe is active when both cs_n and wr_n are low. Either input may be the one that toggles, and the other is held low.
- R3: mode_in is taken only at the falling strobe edge, where 1 selects sequential mode and 0 selects random mode. A change of mode_in with no strobe has no effect.
- R4: In random mode, the location shr_in[2:0] is taken at the falling strobe edge. A change of shr_in after that edge does not alter where the code is written.
- R5: data_in is taken at the rising strobe edge and written into the selected entry. Rd_data shows it for the matching rd_addr. Each strobe edge takes effect within three clocks of the input change.
- R6: In sequential mode, the entry enable shr_in[0] is taken at the falling edge. With the enable high and full low, the code goes to the location given by the counter, and the counter then advances by one. With the enable low, nothing is written and the counter holds.
- R7: full_out rises after eight accepted sequential entries. While full, a sequential write changes no entry.
- R8: When the last taken mode is sequential, shr_in[1] low (active-low clear) resets the counter to 0 and loads every entry with 6'b100000. In random mode, shr_in[1] low is only an address bit and clears nothing.
- R9: full_out is 0 while the last taken mode is random. After a change into sequential mode, full_out becomes valid only after the rising edge of that first sequential strobe.
- R10: wr_active is 1 from the falling to the rising strobe edge exactly when that strobe will write an entry. It is 0 otherwise.
- R11: shutdown high forces full_out to 0 and leaves the counter and the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write line, active low, asynchronous |
| mode_in | input | 1 | Entry mode: 1 sequential, 0 random |
| data_in | input | 6 | Character code |
| shr_in | input | 3 | Shared pins: location in random mode; {unused, clear_n, enable} in sequential mode |
| shutdown | input | 1 | Forces full_out low |
| rd_addr | input | 3 | Scan read location |
| rd_data | output | 6 | Stored code at rd_addr |
| full_out | output | 1 | Sequential memory full |
| wr_active | output | 1 | A committing write is in progress |

## Verification
The hardest situation to reach is the one where the mode change and the full state interact. The counter is full from an earlier sequential fill. A random write then hides the full indication. The next sequential strobe must keep full_out low until its rising edge, while also refusing the write.

The stimulus reaches this state in four steps. It fills the memory with eight enabled sequential writes. It switches to random mode with the clear line held high. It then issues a sequential strobe and samples full_out and wr_active in the middle of that strobe. It samples them again after the strobe ends.

Clear aliasing gets similar attention. After the block is back in random mode, the stimulus holds shr_in[1] low with no strobe, and also while mode_in is raised. It then confirms that the memory is intact.

// File: rtl/charmem_writer_pkg.sv
// Package: shared types for the character memory write controller.
// Assumes: one system clock domain; host signals are synchronized before use.
package charmem_writer_pkg;

    // Entry mode as taken at the falling strobe edge
    typedef enum logic {
        MODE_RAND = 1'b0,
        MODE_SEQ  = 1'b1
    } entry_mode_e;

    // Bit positions of the shared pins in sequential mode
    localparam int SHR_EN_BIT  = 0;
    localparam int SHR_CLR_BIT = 1;

endpackage

// File: rtl/sig_sync.sv
// Module: sig_sync
// Multi-stage synchronizer for a vector of independent asynchronous inputs.
// Assumes: STAGES >= 2; each bit is synchronized on its own (no bus coherency).
module sig_sync #(
    parameter int          STAGES = 2,
    parameter int          N      = 1,
    parameter logic [N-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] shreg;

        // Shift the asynchronous bit through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg <= {STAGES{IDLE[b]}};
            end else begin
                shreg <= {shreg[STAGES-2:0], d_async[b]};
            end
        end

        assign d_sync[b] = shreg[STAGES-1];
    end

endmodule

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Combines the synchronized chip select and write line into one strobe and
// flags its start (falling write edge) and end (rising write edge).
// Assumes: inputs are already synchronized; the events last one clock each.
module strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_s,
    input  logic cs_s,
    output logic fall_ev,
    output logic rise_ev
);

    logic act_now;
    logic act_q;

    // Strobe is active only when both active-low inputs are low
    always_comb act_now = ~wr_s & ~cs_s;

    // Remember the previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_now;
    end

    // Edge events of the combined strobe
    always_comb begin
        fall_ev = act_now & ~act_q;
        rise_ev = ~act_now & act_q;
    end

endmodule

// File: rtl/entry_counter.sv
// Module: entry_counter
// Sequential entry location counter, saturating at DEPTH with a full flag.
// Assumes: inc is never raised while full; clr has priority over inc.
module entry_counter #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);

    logic [CNT_W-1:0] cnt_q;

    // Count accepted entries; clear and reset return to location 0
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (clr)                         cnt_q <= '0;
        else if (inc && cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // Full once DEPTH entries have been accepted
    always_comb full = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/char_store.sv
// Module: char_store
// Register-based character memory with one write port, a combinational
// read port and a clear that loads every entry with the blank code.
// Assumes: clr has priority over we; DEPTH is small (register file).
module char_store #(
    parameter int              DEPTH  = 8,
    parameter int              DATA_W = 6,
    parameter int              ADDR_W = $clog2(DEPTH),
    parameter logic [DATA_W-1:0] BLANK = 6'b100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Hold one entry; blank on reset or clear, load on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                        ent[i] <= BLANK;
            else if (we && waddr == ADDR_W'(i))       ent[i] <= wdata;
        end
    end

    // Scan read port
    always_comb rdata = ent[raddr];

endmodule

// File: rtl/charmem_writer.sv
// Module: charmem_writer (top)
// Host write controller for the character memory, with random and sequential
// entry modes. It synchronizes cs_n, wr_n and the sequential clear; takes
// mode, location and enable at the strobe start, and data at the strobe end.
// Assumes: mode_in, shr_in and data_in stay stable for at least three clocks
// around each strobe edge; shr_in[1] is held high when leaving sequential mode.
module charmem_writer
    import charmem_writer_pkg::*;
#(
    parameter int                DEPTH       = 8,
    parameter int                DATA_W      = 6,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] BLANK       = 6'b100000,
    localparam int               ADDR_W      = $clog2(DEPTH),
    localparam int               CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              mode_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [ADDR_W-1:0] shr_in,
    input  logic              shutdown,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_out,
    output logic              wr_active
);

    logic              wr_s, cs_s, clr_n_s;
    logic              fall_ev, rise_ev;
    entry_mode_e       mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic              go_q;
    logic              fullv_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full_int;
    logic              clear_now;
    logic              we;
    logic [ADDR_W-1:0] waddr;

    sig_sync #(
        .STAGES (SYNC_STAGES),
        .N      (3),
        .IDLE   (3'b111)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({shr_in[SHR_CLR_BIT], cs_n, wr_n}),
        .d_sync  ({clr_n_s, cs_s, wr_s})
    );

    strobe_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_s    (wr_s),
        .cs_s    (cs_s),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    // Clear acts only while the last taken mode is sequential
    always_comb clear_now = (mode_q == MODE_SEQ) && !clr_n_s;

    // Strobe-edge control: mode, location and write decision at the start,
    // full-valid at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_RAND;
            addr_q  <= '0;
            go_q    <= 1'b0;
            fullv_q <= 1'b0;
        end else begin
            if (fall_ev) begin
                mode_q <= entry_mode_e'(mode_in);
                if (mode_in) begin
                    go_q <= shr_in[SHR_EN_BIT] & ~full_int;
                end else begin
                    addr_q  <= shr_in;
                    go_q    <= 1'b1;
                    fullv_q <= 1'b0;
                end
            end else if (rise_ev) begin
                go_q <= 1'b0;
                if (mode_q == MODE_SEQ) fullv_q <= 1'b1;
            end
            if (clear_now) go_q <= 1'b0;
        end
    end

    // Commit at the strobe end to the counter or latched location
    always_comb begin
        we    = rise_ev & go_q & ~clear_now;
        waddr = (mode_q == MODE_SEQ) ? cnt_q[ADDR_W-1:0] : addr_q;
    end

    entry_counter #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_now),
        .inc   (we && mode_q == MODE_SEQ),
        .cnt   (cnt_q),
        .full  (full_int)
    );

    char_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BLANK  (BLANK)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_now),
        .we    (we),
        .waddr (waddr),
        .wdata (data_in),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Outputs toward the host and the scan logic
    always_comb begin
        full_out  = (mode_q == MODE_SEQ) & fullv_q & full_int & ~shutdown;
        wr_active = go_q;
    end

endmodule

// File: rtl/charmem_writer_chk.sv
// Module: charmem_writer_chk
// Property checker for charmem_writer, attached by bind below.
// Assumes: observes ports and a few internal controls of the top.
module charmem_writer_chk
    import charmem_writer_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shutdown,
    input logic             full_out,
    input logic             wr_active,
    input entry_mode_e      mode_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             clear_now,
    input logic             rise_ev
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_active && !full_out));

    // R11
    shut_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !full_out);

    // R9
    full_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RAND) |-> !full_out);

    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_out |-> !wr_active);

    // R7
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R8
    clear_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_now |=> (cnt_q == '0));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

    // R10
    go_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ev |=> !wr_active);

endmodule

bind charmem_writer charmem_writer_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shutdown  (shutdown),
    .full_out  (full_out),
    .wr_active (wr_active),
    .mode_q    (mode_q),
    .cnt_q     (cnt_q),
    .clear_now (clear_now),
    .rise_ev   (rise_ev)
);

// File: tb/charmem_writer_tb.sv
module charmem_writer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       mode_in = 1'b0;
    logic [5:0] data_in = '0;
    logic [2:0] shr_in = 3'b010;
    logic       shutdown = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [5:0] rd_data;
    logic       full_out;
    logic       wr_active;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int mem_m [8];
    int cnt_m   = 0;
    bit mode_m  = 0;
    bit fullv_m = 0;
    bit settled = 0;

    always #2 clk = ~clk;

    charmem_writer u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .mode_in(mode_in), .data_in(data_in), .shr_in(shr_in),
        .shutdown(shutdown), .rd_addr(rd_addr), .rd_data(rd_data),
        .full_out(full_out), .wr_active(wr_active)
    );

    function automatic bit full_exp();
        return mode_m && fullv_m && (cnt_m == 8) && !shutdown;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock comparison of full_out while inputs are settled
    always @(negedge clk) begin
        if (settled && rst_n) check("R9 per-clock full", full_out, full_exp());
    end

    task automatic check_mem(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #0.5;
            check(req, rd_data, mem_m[i]);
        end
        check({req, " full"}, full_out, full_exp());
        check("R10 idle wr_active", wr_active, 0);
    endtask

    // one strobe: use_cs selects cs_n as the toggling input (R2)
    task automatic strobe(input bit use_cs, input bit md, input logic [2:0] shr,
                          input logic [5:0] d, input bit late, input logic [2:0] shr_late);
        bit go_m;
        int addr_m;
        settled = 0;
        mode_in = md; shr_in = shr; data_in = d;
        if (use_cs) wr_n = 1'b0; else cs_n = 1'b0;
        waitc(3);
        if (use_cs) cs_n = 1'b0; else wr_n = 1'b0;
        waitc(6);
        mode_m = md;
        addr_m = shr;
        go_m = md ? (shr[0] && cnt_m < 8) : 1'b1;
        if (!md) fullv_m = 0;
        check("R10 wr_active during strobe", wr_active, go_m);
        check("R9 full during strobe", full_out, full_exp());
        if (late) begin
            shr_in = shr_late;
            waitc(3);
        end
        if (use_cs) cs_n = 1'b1; else wr_n = 1'b1;
        waitc(6);
        if (go_m) begin
            if (md) begin mem_m[cnt_m] = d; cnt_m++; end
            else mem_m[addr_m] = d;
        end
        if (md) fullv_m = 1;
        if (use_cs) wr_n = 1'b1; else cs_n = 1'b1;
        waitc(3);
        settled = 1;
    endtask

    task automatic do_clear();
        settled = 0;
        shr_in[1] = 1'b0;
        waitc(6);
        if (mode_m) begin
            cnt_m = 0;
            for (int i = 0; i < 8; i++) mem_m[i] = 'h20;
        end
        shr_in[1] = 1'b1;
        waitc(4);
        settled = 1;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mem_m[i] = 'h20;
        waitc(4);
        rst_n = 1'b1;
        waitc(2);
        settled = 1;
        // R1 reset state
        check_mem("R1 reset blank");

        // R4 R5 random writes, wr_n as strobe
        strobe(0, 0, 3'd5, 6'h11, 0, 0);
        strobe(0, 0, 3'd0, 6'h3F, 0, 0);
        check_mem("R5 random write");
        // R2 cs_n as strobe
        strobe(1, 0, 3'd7, 6'h2A, 0, 0);
        check_mem("R2 cs strobe");
        // R4 location change after the falling edge is ignored
        strobe(0, 0, 3'd3, 6'h05, 1, 3'd6);
        check_mem("R4 late address");

        // R6 R7 sequential fill
        for (int i = 0; i < 8; i++) strobe(i[0], 1, 3'b011, 6'(8'h10 + i), 0, 0);
        check_mem("R6 sequential fill");
        check("R7 full after eight", full_out, 1);
        strobe(0, 1, 3'b011, 6'h01, 0, 0);
        check_mem("R7 write while full");

        // R11 shutdown masks full only
        settled = 0; shutdown = 1'b1; waitc(2); settled = 1;
        check("R11 full masked", full_out, 0);
        strobe(0, 1, 3'b011, 6'h02, 0, 0);
        check_mem("R11 memory kept");
        settled = 0; shutdown = 1'b0; waitc(2); settled = 1;
        check("R11 full back", full_out, 1);

        // R9 change to random hides full, return to sequential revalidates it
        strobe(0, 0, 3'b010, 6'h33, 0, 0);
        check("R9 full in random", full_out, 0);
        strobe(0, 1, 3'b011, 6'h04, 0, 0);
        check("R9 full after seq rise", full_out, 1);
        check_mem("R9 mode change");

        // R8 clear in sequential mode
        do_clear();
        check_mem("R8 clear");
        check("R8 full after clear", full_out, 0);

        // R6 enable low is ignored
        strobe(0, 1, 3'b010, 6'h07, 0, 0);
        check_mem("R6 enable low");
        strobe(0, 1, 3'b011, 6'h21, 0, 0);
        strobe(1, 1, 3'b011, 6'h22, 0, 0);
        check_mem("R6 restart at location 0");

        // R8 clear bit is only an address bit in random mode
        strobe(0, 0, 3'b110, 6'h16, 0, 0);
        strobe(0, 0, 3'b100, 6'h14, 0, 0);
        check_mem("R8 random bit1 low");
        do_clear();
        check_mem("R8 no clear in random");

        // R3 mode_in without a strobe has no effect
        settled = 0; mode_in = 1'b1; shr_in = 3'b000; waitc(8); settled = 1;
        check_mem("R3 mode not taken");
        shr_in = 3'b010; mode_in = 1'b0; waitc(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule